// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Array

This block holds the per-function vector table for message-signalled interrupts, together with the bit array that records events held back by masking. Software reaches both through a 32-bit register port. One select pin chooses between the table and the pending array. Reads are combinational. Writes take effect at the clock edge. Each vector entry stores a 64-bit message address, a 32-bit data word and a mask bit. Inside the device, an event input names a vector to fire. A pair of claim/release pins keeps a use count for each vector. The block delivers at most one message at a time through a valid/ready output.

An event is delivered only when three things hold: its vector exists, the vector has a nonzero use count, and the vector is not masked. A vector is masked when its own mask bit is set or when the function-wide mask pin is high. An event on a masked vector is recorded in the pending array and sends nothing. When the vector later becomes unmasked, through a table write or through the function mask dropping, its pending bit is cleared and the message is queued for replay. Queued replays go out before any new event and in ascending vector order.

Back-pressure works as follows. After `msg_valid` rises, `msg_addr` and `msg_data` stay unchanged until a cycle in which `msg_ready` is high. The next message can be launched no earlier than the cycle after that handshake. `ev_ready` is low while a message is outstanding or any replay is queued. An event is taken only in a cycle with `ev_valid` and `ev_ready` both high.

Top module: `msix_vector_table`

## Requirements
- R1: After reset, every table word reads zero except the control word, which reads 1 (mask set). The pending array reads zero and `msg_valid` is low.
- R2: Table byte address A selects vector A/16, and bits A[1:0] are ignored. Word offsets within an entry: 0 is address bits 31:0, 4 is address bits 63:32, 8 is the data word, 12 is control. Control bit 0 is the mask bit and the other control bits read 0. Table accesses to a vector at or above the vector count read 0, and writes to them are ignored.
- R3: The pending bit for vector v is bit v%32 of the pending word at byte offset 4*(v/32). The array spans the vector count rounded up to 64 bits. Words past the vectors read 0. Writes to the pending array are ignored.
- R4: An event taken on an in-range, claimed, unmasked vector raises `msg_valid` in the next cycle, carrying that entry's address and data.
- R5: An event taken on a claimed vector whose mask bit is set, or while `func_mask` is high, sets its pending bit and sends no message.
- R6: An event on a vector at or above the vector count, or on a vector with a zero use count, changes nothing and sends no message.
- R7: When a vector goes from masked to unmasked with its pending bit set, the pending bit clears and the message is sent. This holds whether the cause is a control-word write or `func_mask` falling.
- R8: Use counts are 8 bits. A claim increments (saturating at 255). A release decrements (ignored at 0). A claim and a release on the same vector in the same cycle cancel. `use_err` is high in the same cycle as a claim on an out-of-range vector. A release that brings a count to 0 clears that vector's pending bit and cancels its replay.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. `ev_ready` is low while `msg_valid` is high or a replay is queued.
- R10: Queued replays are issued one at a time in ascending vector order, ahead of new events.
- R11: If an event arrives on a masked vector in the same cycle as a write that unmasks that vector, the event is not lost: its message is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_pba | input | 1 | 1 selects the pending array, 0 the vector table |
| reg_addr | input | REG_AW | Byte address within the selected region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| func_mask | input | 1 | Function-wide mask |
| ev_valid | input | 1 | Event request |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_vec | input | IDX_W | Event vector number |
| use_inc | input | 1 | Claim the vector on use_vec |
| use_dec | input | 1 | Release the vector on use_vec |
| use_vec | input | IDX_W | Vector for claim/release |
| use_err | output | 1 | Claim rejected (vector out of range) |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Several functions can land on the same vector in the same cycle. The bench provokes two such collisions on purpose. In the first, an event hits a masked vector while a control write unmasks it: the bench drives both in one cycle and expects exactly one message and a clear pending bit. In the second, a release drops a masked, pending vector's count to zero, and the later unmask must produce no message. The bench also forces a collision between the replay queue and new events by dropping the function mask with several vectors pending. It then checks that the messages appear in ascending vector order and that `ev_ready` stays low until the queue is empty.

// File: rtl/msix_vt_pkg.sv
package msix_vt_pkg;
  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic        mask;
  } vec_entry_t;

  localparam logic [1:0] W_ADDR_LO = 2'd0;
  localparam logic [1:0] W_ADDR_HI = 2'd1;
  localparam logic [1:0] W_DATA    = 2'd2;
  localparam logic [1:0] W_CTRL    = 2'd3;
  localparam int         USE_CW    = 8;
endpackage

// File: rtl/msix_vt_table.sv
module msix_vt_table
  import msix_vt_pkg::*;
#(
  parameter int N_VEC = 12,
  parameter int VW    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [VW-1:0] wr_vec,
  input  logic [1:0]  wr_word,
  input  logic [31:0] wr_data,
  output vec_entry_t  ent_o [N_VEC]
);
  for (genvar v = 0; v < N_VEC; v++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_vec == VW'(v));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_o[v].addr <= '0;
        ent_o[v].data <= '0;
        ent_o[v].mask <= 1'b1;
      end else if (hit) begin
        case (wr_word)
          W_ADDR_LO: ent_o[v].addr[31:0]  <= wr_data;
          W_ADDR_HI: ent_o[v].addr[63:32] <= wr_data;
          W_DATA:    ent_o[v].data        <= wr_data;
          default:   ent_o[v].mask        <= wr_data[0];
        endcase
      end
    end
  end
endmodule

// File: rtl/msix_vt_usecnt.sv
module msix_vt_usecnt
  import msix_vt_pkg::*;
#(
  parameter int N_VEC = 12,
  parameter int VW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             vec_ok,
  input  logic [VW-1:0]    vec,
  output logic [N_VEC-1:0] live_o,
  output logic [N_VEC-1:0] drop_o
);
  localparam logic [USE_CW-1:0] CNT_MAX = '1;

  for (genvar v = 0; v < N_VEC; v++) begin : g_cnt
    logic [USE_CW-1:0] cnt;
    logic hit, up, dn;
    assign hit = vec_ok && (vec == VW'(v));
    assign up  = hit && inc && !dec;
    assign dn  = hit && dec && !inc;
    always_ff @(posedge clk) begin
      if (!rst_n)                       cnt <= '0;
      else if (up && cnt != CNT_MAX)    cnt <= cnt + 1'b1;
      else if (dn && cnt != '0)         cnt <= cnt - 1'b1;
    end
    assign live_o[v] = (cnt != '0);
    assign drop_o[v] = dn && (cnt == USE_CW'(1));
  end
endmodule

// File: rtl/msix_vt_pend.sv
module msix_vt_pend #(
  parameter int N_VEC = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_VEC-1:0] set_i,
  input  logic [N_VEC-1:0] unmask_i,
  input  logic [N_VEC-1:0] drop_i,
  input  logic [N_VEC-1:0] grant_i,
  output logic [N_VEC-1:0] pend_o,
  output logic [N_VEC-1:0] replay_o
);
  logic [N_VEC-1:0] held, trig;

  assign held = pend_o | set_i;
  assign trig = held & unmask_i & ~drop_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o   <= '0;
      replay_o <= '0;
    end else begin
      pend_o   <= held & ~(trig | drop_i);
      replay_o <= (replay_o & ~grant_i & ~drop_i) | trig;
    end
  end
endmodule

// File: rtl/msix_vt_issue.sv
module msix_vt_issue
  import msix_vt_pkg::*;
#(
  parameter int N_VEC = 12,
  parameter int VW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_VEC-1:0] replay_i,
  input  vec_entry_t       ent_i [N_VEC],
  input  logic             ev_go,
  input  logic [VW-1:0]    ev_vec,
  input  logic             msg_ready,
  output logic             msg_valid,
  output logic [63:0]      msg_addr,
  output logic [31:0]      msg_data,
  output logic [N_VEC-1:0] grant_o
);
  logic [VW-1:0] gidx;
  logic          found;

  always_comb begin
    gidx  = '0;
    found = 1'b0;
    for (int i = N_VEC - 1; i >= 0; i--) begin
      if (replay_i[i]) begin
        gidx  = VW'(i);
        found = 1'b1;
      end
    end
    grant_o = '0;
    if (!msg_valid && found) grant_o[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (!msg_valid) begin
      if (found) begin
        msg_valid <= 1'b1;
        msg_addr  <= ent_i[gidx].addr;
        msg_data  <= ent_i[gidx].data;
      end else if (ev_go) begin
        msg_valid <= 1'b1;
        msg_addr  <= ent_i[ev_vec].addr;
        msg_data  <= ent_i[ev_vec].data;
      end
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msix_vector_table.sv
module msix_vector_table
  import msix_vt_pkg::*;
#(
  parameter int N_VEC  = 12,
  parameter int IDX_W  = 12,
  parameter int REG_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_pba,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              func_mask,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [IDX_W-1:0]  ev_vec,
  input  logic              use_inc,
  input  logic              use_dec,
  input  logic [IDX_W-1:0]  use_vec,
  output logic              use_err,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int VW        = (N_VEC > 1) ? $clog2(N_VEC) : 1;
  localparam int PBA_W     = ((N_VEC + 63) / 64) * 64;
  localparam int PBA_WORDS = PBA_W / 32;

  vec_entry_t       ent [N_VEC];
  logic [N_VEC-1:0] live, drop, pend_bits, replay_bits, grant, pend_set, unmask;
  logic             func_q;

  // register port decode
  logic [REG_AW-5:0] t_vec_full;
  logic [VW-1:0]     t_vec;
  logic              t_ok, tw_en;
  logic [1:0]        t_word;
  assign t_vec_full = reg_addr[REG_AW-1:4];
  assign t_vec      = t_vec_full[VW-1:0];
  assign t_ok       = int'(t_vec_full) < N_VEC;
  assign t_word     = reg_addr[3:2];
  assign tw_en      = reg_wr && !reg_pba && t_ok;

  logic [PBA_W-1:0]  pba_ext;
  logic [REG_AW-3:0] p_word;
  assign p_word = reg_addr[REG_AW-1:2];

  always_comb begin
    pba_ext = '0;
    pba_ext[N_VEC-1:0] = pend_bits;
    reg_rdata = '0;
    if (reg_pba) begin
      for (int w = 0; w < PBA_WORDS; w++)
        if (int'(p_word) == w) reg_rdata = pba_ext[w*32 +: 32];
    end else if (t_ok) begin
      case (t_word)
        W_ADDR_LO: reg_rdata = ent[t_vec].addr[31:0];
        W_ADDR_HI: reg_rdata = ent[t_vec].addr[63:32];
        W_DATA:    reg_rdata = ent[t_vec].data;
        default:   reg_rdata = {31'd0, ent[t_vec].mask};
      endcase
    end
  end

  // event decode
  logic          ev_ok, ev_take, ev_masked, ev_go;
  logic [VW-1:0] ev_v;
  assign ev_ok     = int'(ev_vec) < N_VEC;
  assign ev_v      = ev_vec[VW-1:0];
  assign ev_ready  = !msg_valid && (replay_bits == '0);
  assign ev_take   = ev_valid && ev_ready && ev_ok && live[ev_v];
  assign ev_masked = ent[ev_v].mask || func_mask;
  assign ev_go     = ev_take && !ev_masked;

  always_comb begin
    pend_set = '0;
    if (ev_take && ev_masked) pend_set[ev_v] = 1'b1;
  end

  // effective-mask transitions, from a control write or the function mask
  always_ff @(posedge clk) begin
    if (!rst_n) func_q <= 1'b0;
    else        func_q <= func_mask;
  end

  for (genvar v = 0; v < N_VEC; v++) begin : g_unmask
    logic after_mask;
    assign after_mask = (tw_en && t_vec == VW'(v) && t_word == W_CTRL) ?
                        reg_wdata[0] : ent[v].mask;
    assign unmask[v]  = (ent[v].mask || func_q) && !(after_mask || func_mask);
  end

  logic use_ok;
  assign use_ok  = int'(use_vec) < N_VEC;
  assign use_err = use_inc && !use_ok;

  msix_vt_table #(.N_VEC(N_VEC), .VW(VW)) table_i (
    .clk(clk), .rst_n(rst_n), .wr_en(tw_en), .wr_vec(t_vec),
    .wr_word(t_word), .wr_data(reg_wdata), .ent_o(ent)
  );

  msix_vt_usecnt #(.N_VEC(N_VEC), .VW(VW)) use_i (
    .clk(clk), .rst_n(rst_n), .inc(use_inc), .dec(use_dec), .vec_ok(use_ok),
    .vec(use_vec[VW-1:0]), .live_o(live), .drop_o(drop)
  );

  msix_vt_pend #(.N_VEC(N_VEC)) pend_i (
    .clk(clk), .rst_n(rst_n), .set_i(pend_set), .unmask_i(unmask),
    .drop_i(drop), .grant_i(grant), .pend_o(pend_bits), .replay_o(replay_bits)
  );

  msix_vt_issue #(.N_VEC(N_VEC), .VW(VW)) issue_i (
    .clk(clk), .rst_n(rst_n), .replay_i(replay_bits), .ent_i(ent),
    .ev_go(ev_go), .ev_vec(ev_v), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .grant_o(grant)
  );
endmodule

// File: rtl/msix_vt_chk.sv
module msix_vt_chk #(
  parameter int N_VEC = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [63:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic             ev_ready,
  input logic             use_inc,
  input logic             use_err,
  input logic [N_VEC-1:0] pend_bits,
  input logic [N_VEC-1:0] replay_bits
);
  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R9
  ev_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !ev_ready);

  // R10
  replay_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_bits != '0) |-> !ev_ready);

  // R8
  use_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_err |-> use_inc);

  // R7
  pend_replay_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_bits & replay_bits) == '0);
endmodule

bind msix_vector_table msix_vt_chk #(.N_VEC(N_VEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .ev_ready(ev_ready),
  .use_inc(use_inc), .use_err(use_err), .pend_bits(pend_bits),
  .replay_bits(replay_bits)
);

// File: tb/msix_vector_table_tb_top.sv
module msix_vector_table_tb_top;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_pba = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        func_mask = 1'b0;
  logic        ev_valid = 1'b0, ev_ready;
  logic [11:0] ev_vec = '0;
  logic        use_inc = 1'b0, use_dec = 1'b0, use_err;
  logic [11:0] use_vec = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  msix_vector_table #(.N_VEC(NV)) dut_i (.*);

  always #5 clk = ~clk;

  logic [63:0] m_addr [NV];
  logic [31:0] m_data [NV];
  bit          m_mask [NV];
  bit          m_pend [NV];
  int          m_use  [NV];
  bit          fm = 1'b0;
  int          exp_q[$];
  int          n_chk = 0, n_bad = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int v, int w);
    if (v >= NV) return 32'd0;
    case (w)
      0: return m_addr[v][31:0];
      1: return m_addr[v][63:32];
      2: return m_data[v];
      default: return {31'd0, m_mask[v]};
    endcase
  endfunction

  function automatic logic [31:0] exp_pba(int w);
    logic [31:0] r = '0;
    for (int v = 0; v < NV; v++) if (v / 32 == w) r[v % 32] = m_pend[v];
    return r;
  endfunction

  function automatic void model_write(int v, int w, logic [31:0] d);
    bit was;
    if (v >= NV) return;
    was = m_mask[v] | fm;
    case (w)
      0: m_addr[v][31:0]  = d;
      1: m_addr[v][63:32] = d;
      2: m_data[v]        = d;
      default: m_mask[v]  = d[0];
    endcase
    if (was && !(m_mask[v] | fm) && m_pend[v]) begin
      m_pend[v] = 1'b0;
      exp_q.push_back(v);
    end
  endfunction

  function automatic void model_event(int v);
    if (v >= NV || m_use[v] == 0) return;
    if (m_mask[v] | fm) m_pend[v] = 1'b1;
    else exp_q.push_back(v);
  endfunction

  task automatic tb_write(int v, int w, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_pba = 1'b0; reg_addr = 16'(v * 16 + w * 4); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    model_write(v, w, d);
  endtask

  task automatic tb_read_tab(int v, int w, int lowbits, string req);
    @(negedge clk);
    reg_pba = 1'b0; reg_addr = 16'(v * 16 + w * 4 + lowbits);
    #1 chk(req, reg_rdata, exp_word(v, w));
  endtask

  task automatic tb_read_pba(string req);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      reg_pba = 1'b1; reg_addr = 16'(w * 4);
      #1 chk(req, reg_rdata, exp_pba(w));
    end
    reg_pba = 1'b0;
  endtask

  task automatic tb_event(int v);
    @(negedge clk);
    chk("R9 ev_ready idle", ev_ready, 1);
    ev_valid = 1'b1; ev_vec = 12'(v);
    @(posedge clk); #1;
    ev_valid = 1'b0;
    model_event(v);
  endtask

  task automatic tb_use(int v, bit inc, bit dec);
    @(negedge clk);
    use_inc = inc; use_dec = dec; use_vec = 12'(v);
    #1 chk("R8 use_err", use_err, (inc && v >= NV) ? 1 : 0);
    @(posedge clk); #1;
    use_inc = 1'b0; use_dec = 1'b0;
    if (v < NV && inc && !dec && m_use[v] < 255) m_use[v]++;
    else if (v < NV && dec && !inc && m_use[v] > 0) begin
      m_use[v]--;
      if (m_use[v] == 0) m_pend[v] = 1'b0;
    end
  endtask

  task automatic tb_fm(bit x);
    @(negedge clk);
    func_mask = x;
    @(posedge clk); #1;
    if (fm && !x)
      for (int v = 0; v < NV; v++)
        if (!m_mask[v] && m_pend[v]) begin
          m_pend[v] = 1'b0;
          exp_q.push_back(v);
        end
    fm = x;
  endtask

  task automatic drain(string req);
    while (exp_q.size() > 0) begin
      int v = exp_q.pop_front();
      int t = 0;
      @(negedge clk);
      while (!msg_valid && t < 6) begin @(negedge clk); t++; end
      chk({req, " msg_valid"}, msg_valid, 1);
      chk({req, " msg_addr"}, msg_addr, m_addr[v]);
      chk({req, " msg_data"}, msg_data, m_data[v]);
      msg_ready = 1'b1;
      @(posedge clk); #1;
      msg_ready = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk({req, " no extra message"}, msg_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r;
    for (int v = 0; v < NV; v++) begin
      m_addr[v] = '0; m_data[v] = '0; m_mask[v] = 1'b1; m_pend[v] = 1'b0; m_use[v] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 msg_valid", msg_valid, 0);
    tb_read_tab(0, 3, 0, "R1 ctrl");
    tb_read_tab(5, 0, 0, "R1 addr");
    tb_read_pba("R1 pending");

    for (int v = 0; v < NV; v++) begin
      tb_write(v, 0, 32'hFEE0_0000 + 32'(v * 16));
      tb_write(v, 1, 32'hA000_0000 + 32'(v));
      tb_write(v, 2, 32'h100 + 32'(v));
      tb_write(v, 3, 32'h0);
    end

    // R6 unclaimed and out-of-range events
    tb_event(3);
    tb_event(13);
    drain("R6");
    tb_read_pba("R6 pending");

    for (int v = 0; v < NV; v++) if (v != 9) tb_use(v, 1, 0);
    tb_use(14, 1, 0);

    // R4 plain delivery
    tb_event(3);
    drain("R4");

    // R9 stall holds the message
    tb_event(4);
    repeat (3) @(negedge clk);
    chk("R9 held valid", msg_valid, 1);
    chk("R9 held addr", msg_addr, m_addr[4]);
    chk("R9 ev_ready blocked", ev_ready, 0);
    drain("R9");

    // R5 own mask, R7 replay on unmask
    tb_write(6, 3, 32'h1);
    tb_event(6);
    drain("R5");
    tb_read_pba("R5 pending");
    tb_write(6, 3, 32'h0);
    drain("R7");
    tb_read_pba("R7 pending");

    // R5 function mask, R3 pending writes ignored, R10 ascending replay
    tb_fm(1);
    tb_event(7); tb_event(2); tb_event(5);
    drain("R5 func");
    @(negedge clk);
    reg_wr = 1'b1; reg_pba = 1'b1; reg_addr = 16'h0; reg_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1 reg_wr = 1'b0;
    tb_read_pba("R3 write ignored");
    tb_fm(0);
    @(negedge clk);
    chk("R10 ev_ready during replays", ev_ready, 0);
    drain("R10");

    // R8 saturation and release to zero
    repeat (260) tb_use(1, 1, 0);
    repeat (254) tb_use(1, 0, 1);
    tb_use(1, 1, 1);
    tb_event(1);
    drain("R8 count one");
    tb_use(1, 0, 1);
    tb_event(1);
    drain("R8 count zero");
    tb_write(8, 3, 32'h1);
    tb_event(8);
    tb_read_pba("R8 pending set");
    tb_use(8, 0, 1);
    tb_read_pba("R8 pending cleared");
    tb_write(8, 3, 32'h0);
    drain("R8 no replay");

    // R11 masked event and unmasking write in one cycle
    tb_write(10, 3, 32'h1);
    @(negedge clk);
    ev_valid = 1'b1; ev_vec = 12'd10;
    reg_wr = 1'b1; reg_pba = 1'b0; reg_addr = 16'(10 * 16 + 12); reg_wdata = 32'h0;
    @(posedge clk); #1;
    ev_valid = 1'b0; reg_wr = 1'b0;
    m_mask[10] = 1'b0;
    exp_q.push_back(10);
    drain("R11");
    tb_read_pba("R11 pending");

    // R2 layout details
    tb_read_tab(2, 1, 0, "R2 addr hi");
    tb_read_tab(2, 2, 2, "R2 low bits ignored");
    tb_write(3, 3, 32'hFFFF_FFFE);
    tb_read_tab(3, 3, 0, "R2 ctrl upper bits");
    tb_write(12, 2, 32'hDEAD_BEEF);
    tb_read_tab(12, 2, 0, "R2 out of range");

    // constrained random mix
    r = $urandom(32'd2024);
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 6);
      int v  = $urandom_range(0, 13);
      case (op)
        0: tb_write(v % 13, $urandom_range(0, 3), $urandom());
        1: tb_write(v % 12, 3, 32'($urandom_range(0, 1)));
        2, 3: tb_event(v);
        4: tb_use(v, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        5: tb_fm(1'($urandom_range(0, 1)));
        default: tb_read_tab(v % 12, $urandom_range(0, 3), 0, "R2 random read");
      endcase
      drain("R4 random");
      if (i % 40 == 0) tb_read_pba("R3 random pending");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule